// File: doc/BRIEF.md
# Masked Round-Robin Next-Grant Selector

This block decides which of N requesters is served next in a rotating schedule. A one-hot vector names the requester that was served most recently, and a request vector of the same width marks the requesters that currently want service. The block returns a one-hot vector naming the first requester at or after that position in wrap-around order that is actually requesting. If nobody requests, it returns zero. The search starts at the index just above the current one, moves toward higher indices, wraps from N-1 to 0, and ends at the current index itself.

The selection is purely combinational. Each output bit is a parallel AND/OR expression produced by generate loops. There is no subtractor and no borrow chain, so the logic depth grows with log N rather than with N.

A registered pointer wraps a second copy of the selector so the rotation can be driven over time. When the step input is raised and at least one request is present, the pointer loads the selector's result and becomes the new current position.

Top module: `rr_next_sel`

## Requirements
- R1: `cur_i` is one-hot, and bit i set means requester i was served last. `nxt_o` is the one-hot vector of the first index in the order i+1, i+2, …, N-1, 0, …, i whose `req_i` bit is 1. For example, with N=8, current 2 and requests {5,6}, the result is bit 5.
- R2: `nxt_o` never has a bit set where `req_i` is 0.
- R3: When `req_i` is all zeros, `nxt_o` is all zeros.
- R4: When the only set bit of `req_i` is the current index, `nxt_o` equals `cur_i`.
- R5: The search wraps from index N-1 to index 0. For example, with N=8, current 6 and requests {1,3}, the result is bit 1; with current 7 and a request on 0 only, the result is bit 0.
- R6: `nxt_o` and `ptr_nxt_o` are always one-hot or all-zero.
- R7: After reset, `ptr_o` is one-hot on index N-1, so the first search from the pointer begins at index 0.
- R8: When `step_i` is 1 and `req_i` is nonzero at a rising clock edge, `ptr_o` takes the value that `ptr_nxt_o` had before that edge. `ptr_nxt_o` is the R1 selection applied to `ptr_o` and `req_i`.
- R9: When `step_i` is 0, or `req_i` is all zeros, `ptr_o` keeps its value across the edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the pointer register |
| rst_n | input | 1 | Active-low asynchronous reset |
| cur_i | input | N | One-hot last-served index for the direct selection |
| req_i | input | N | Request vector, one bit per requester |
| step_i | input | 1 | Advance the pointer to its next grant |
| nxt_o | output | N | Next grant selected from `cur_i` and `req_i` |
| ptr_o | output | N | Registered one-hot pointer |
| ptr_nxt_o | output | N | Next grant selected from `ptr_o` and `req_i` |

## Verification
The hardest case to reach is a long run of non-requesting slots between the current index and the winner, especially a run that crosses the wrap from N-1 to 0. Random request vectors with uniform bits almost never produce such runs at wider N. The stimulus therefore walks every current index and mixes fully random masks with sparse ones that hold only one or two bits. It also adds directed masks: empty, self-only, all-ones, and the two worked wrap cases. The degenerate widths N=1 and N=2 are instantiated alongside N=5 and N=8 so that the wrap arithmetic is exercised where it collapses onto itself.

// File: rtl/rr_pkg.sv
package rr_pkg;

    // Map any signed offset onto 0..n-1 (modulo with a non-negative result).
    function automatic int wrap_idx(input int i, input int n);
        return ((i % n) + n) % n;
    endfunction

endpackage

// File: rtl/rr_pick.sv
// Combinational round-robin pick: for every output bit j, scan back over
// distances d = 1..N to find the current one-hot bit, and require that no
// request lies strictly between it and j.
module rr_pick #(
    parameter int N = 8
) (
    input  logic [N-1:0] cur_i,
    input  logic [N-1:0] req_i,
    output logic [N-1:0] gnt_o
);
    for (genvar j = 0; j < N; j++) begin : g_bit
        // rq_w[e] is the request e positions below j (cyclic); rq_w[0] unused.
        logic [N-1:0] rq_w;
        logic [N:1]   hit_w;

        assign rq_w[0] = 1'b0;
        for (genvar e = 1; e < N; e++) begin : g_rq
            assign rq_w[e] = req_i[rr_pkg::wrap_idx(j - e, N)];
        end

        for (genvar d = 1; d <= N; d++) begin : g_hit
            assign hit_w[d] = cur_i[rr_pkg::wrap_idx(j - d, N)] & ~(|rq_w[d-1:0]);
        end

        assign gnt_o[j] = req_i[j] & (|hit_w);
    end
endmodule

// File: rtl/rr_ptr.sv
module rr_ptr #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         step_i,
    input  logic [N-1:0] req_i,
    input  logic [N-1:0] nxt_i,
    output logic [N-1:0] ptr_o
);
    localparam logic [N-1:0] PTR_RST = {1'b1, {(N-1){1'b0}}} >> 0;

    typedef struct packed {
        logic [N-1:0] ptr;
    } ptr_st_t;

    ptr_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (step_i && (|req_i)) begin
            st_d.ptr = nxt_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.ptr <= PTR_RST;
        end else begin
            st_q <= st_d;
        end
    end

    assign ptr_o = st_q.ptr;

    // R7
    ptr_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot(st_q.ptr));

    // R9
    ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!step_i || !(|req_i)) |=> $stable(st_q.ptr));
endmodule

// File: rtl/rr_next_sel.sv
module rr_next_sel #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] cur_i,
    input  logic [N-1:0] req_i,
    input  logic         step_i,
    output logic [N-1:0] nxt_o,
    output logic [N-1:0] ptr_o,
    output logic [N-1:0] ptr_nxt_o
);
    logic [N-1:0] ptr_w;
    logic [N-1:0] ptr_nxt_w;

    rr_pick #(.N(N)) u_pick_cur (
        .cur_i (cur_i),
        .req_i (req_i),
        .gnt_o (nxt_o)
    );

    rr_pick #(.N(N)) u_pick_ptr (
        .cur_i (ptr_w),
        .req_i (req_i),
        .gnt_o (ptr_nxt_w)
    );

    rr_ptr #(.N(N)) u_ptr (
        .clk    (clk),
        .rst_n  (rst_n),
        .step_i (step_i),
        .req_i  (req_i),
        .nxt_i  (ptr_nxt_w),
        .ptr_o  (ptr_w)
    );

    assign ptr_o     = ptr_w;
    assign ptr_nxt_o = ptr_nxt_w;

    // R6
    grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(nxt_o) && $onehot0(ptr_nxt_w));

    // R2
    grant_in_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr_nxt_w & ~req_i) == '0);

    // R3
    idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i == '0) |-> (ptr_nxt_w == '0));

    // R8
    ptr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && (|req_i)) |=> (ptr_w == $past(ptr_nxt_w)));

    // R4
    self_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i == ptr_w) |-> (ptr_nxt_w == ptr_w));
endmodule

// File: tb/rr_next_sel_bench.sv
module rr_next_sel_bench;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    int vectors = 0;
    int fails   = 0;
    bit done    = 1'b0;

    logic [15:0] cur_v [4];
    logic [15:0] req_v [4];
    logic [15:0] nxt_v [4];
    logic [15:0] ptr_v;
    logic [15:0] pnx_v;
    logic        step;
    int          width [4] = '{8, 1, 2, 5};

    logic [7:0] p8, pn8;
    assign ptr_v = {8'h00, p8};
    assign pnx_v = {8'h00, pn8};

    logic [7:0] n8;
    logic [0:0] n1;
    logic [1:0] n2;
    logic [4:0] n5;
    logic [0:0] dp1, dn1;
    logic [1:0] dp2, dn2;
    logic [4:0] dp5, dn5;

    assign nxt_v[0] = {8'h00, n8};
    assign nxt_v[1] = {15'h0, n1};
    assign nxt_v[2] = {14'h0, n2};
    assign nxt_v[3] = {11'h0, n5};

    rr_next_sel #(.N(8)) u_rr_next_sel (
        .clk(clk), .rst_n(rst_n), .cur_i(cur_v[0][7:0]), .req_i(req_v[0][7:0]),
        .step_i(step), .nxt_o(n8), .ptr_o(p8), .ptr_nxt_o(pn8));
    rr_next_sel #(.N(1)) u_n1 (
        .clk(clk), .rst_n(rst_n), .cur_i(cur_v[1][0:0]), .req_i(req_v[1][0:0]),
        .step_i(1'b0), .nxt_o(n1), .ptr_o(dp1), .ptr_nxt_o(dn1));
    rr_next_sel #(.N(2)) u_n2 (
        .clk(clk), .rst_n(rst_n), .cur_i(cur_v[2][1:0]), .req_i(req_v[2][1:0]),
        .step_i(1'b0), .nxt_o(n2), .ptr_o(dp2), .ptr_nxt_o(dn2));
    rr_next_sel #(.N(5)) u_n5 (
        .clk(clk), .rst_n(rst_n), .cur_i(cur_v[3][4:0]), .req_i(req_v[3][4:0]),
        .step_i(1'b0), .nxt_o(n5), .ptr_o(dp5), .ptr_nxt_o(dn5));

    function automatic logic [15:0] model(input logic [15:0] cur,
                                          input logic [15:0] req, input int n);
        int k = 0;
        for (int i = 0; i < n; i++) if (cur[i]) k = i;
        for (int d = 1; d <= n; d++) begin
            int idx = (k + d) % n;
            if (req[idx]) return 16'(1) << idx;
        end
        return '0;
    endfunction

    task automatic check(input string tag, input logic [15:0] act,
                         input logic [15:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic apply(input int u, input logic [15:0] cur, input logic [15:0] req);
        logic [15:0] exp;
        string tag;
        cur_v[u] = cur;
        req_v[u] = req;
        #1;
        exp = model(cur, req, width[u]);
        if (req == 16'h0)      tag = "R3 idle";
        else if (req == cur)   tag = "R4 self-only";
        else                   tag = "R1 next grant";
        check(tag, nxt_v[u], exp);
        check("R2 grant subset", nxt_v[u] & ~req, 16'h0);
        check("R6 onehot0", 16'($countones(nxt_v[u]) > 1), 16'h0);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        logic [15:0] m, lim, expp, prev;
        void'($urandom(32'd7));
        for (int u = 0; u < 4; u++) begin cur_v[u] = 16'h1; req_v[u] = '0; end
        step = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check("R7 reset pointer", ptr_v, 16'h0080);

        // R1 / R5 worked examples at N=8
        apply(0, 16'h0004, 16'h0060);
        check("R1 example", nxt_v[0], 16'h0020);
        apply(0, 16'h0040, 16'h000A);
        check("R5 wrap example", nxt_v[0], 16'h0002);
        apply(0, 16'h0080, 16'h0001);
        check("R5 top to zero", nxt_v[0], 16'h0001);

        for (int u = 0; u < 4; u++) begin
            lim = (16'(1) << width[u]) - 16'h1;
            for (int k = 0; k < width[u]; k++) begin
                apply(u, 16'(1) << k, 16'h0);
                apply(u, 16'(1) << k, 16'(1) << k);
                apply(u, 16'(1) << k, lim);
                for (int r = 0; r < 40; r++) begin
                    case (r % 3)
                        0: m = 16'($urandom) & lim;
                        1: m = 16'(1) << ($urandom % width[u]);
                        default: m = (16'(1) << ($urandom % width[u])) |
                                     (16'(1) << ($urandom % width[u]));
                    endcase
                    apply(u, 16'(1) << k, m);
                end
            end
        end

        // R8 / R9: pointer walk on the N=8 instance
        for (int s = 0; s < 300; s++) begin
            @(negedge clk);
            step = 1'($urandom % 4 != 0);
            m = (s % 5 == 0) ? 16'h0 : (16'($urandom) & 16'h00FF);
            req_v[0] = m;
            #1;
            prev = ptr_v;
            expp = (step && m != 0) ? model(prev, m, 8) : prev;
            check("R8 ptr next view", pnx_v, model(prev, m, 8));
            @(posedge clk);
            #1;
            check((step && m != 0) ? "R8 ptr load" : "R9 ptr hold", ptr_v, expp);
        end
        step = 1'b0;

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule